// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational binary adder. It takes two operands and a carry-in, and returns their sum and a carry-out. The operand is cut into consecutive blocks, and each block is one bit wider than the block below it. The lowest block is a single ripple chain driven by the external carry-in.

Every higher block ripples its carry twice at the same time. One chain assumes an incoming carry of 0 and the other assumes 1. Inside each block, a setup stage forms per-bit propagate (`a ^ b`) and generate (`a & b`) terms, and both chains reuse them. When the real carry arrives from the block below, a 2:1 multiplexer picks that block's sum bits and its carry-out.

Because the widths grow block by block, each block's two ripples finish at about the moment its selecting carry arrives. The path from carry-in to carry-out therefore crosses one multiplexer per block, not one ripple stage per bit.

The partition is a parameter. It is a packed vector of 8-bit block widths, with block 0 in the lowest byte. The widths must add up to the operand width, and a mismatch stops elaboration. Setting every width equal gives the uniform carry-select arrangement.

There is no clock and no state, so there are no states or transitions to list. The result is valid in the same cycle in which the inputs are applied.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every operand pair and carry-in, `{co, sum}` equals `a + b + ci` computed at `WIDTH + 1` bits.
- R2: With the default parameters (`WIDTH` = 20), the blocks from low to high are 2, 3, 4, 5 and 6 bits wide. They cover bits 0–1, 2–4, 5–8, 9–13 and 14–19. A carry formed in the top bit of one block appears in the lowest bit of the next block, at bit positions 2, 5, 9 and 14.
- R3: The lowest block is a single ripple chain fed by `ci`. A carry-in alone adds exactly one, and a carry produced inside bits 0–1 reaches bit 2.
- R4: Each block above the first computes its sums and carry-out for both possible carry-ins. The carry-out assuming 1 is never lower than the carry-out assuming 0. The real incoming carry selects the result, and that same selected carry becomes the next block's incoming carry.
- R5: When every bit position propagates (`a ^ b` all ones), `co` equals `ci`. The sum is then all ones for `ci` = 0 and all zeros for `ci` = 1.
- R6: A carry generated in bit 0 ripples through every block. For `a` = 1 and `b` all ones, the result is a zero sum with `co` = 1.
- R7: `co` is the selected carry-out of the highest block. When both operand MSBs are set, `co` = 1 and the sum MSB equals the carry into that bit.
- R8: A 16-bit instance with four 4-bit blocks (the uniform variant) meets R1.
- R9: A partition that contains 1-bit blocks meets R1. A 6-bit instance with blocks of 1, 2 and 3 bits is correct for all 2^13 input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| ci | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| co | output | 1 | Carry out of the top bit |

## Verification
The adder holds no registers, so every result is due zero cycles after its stimulus. Each driven vector settles within the same clock period.

The driver applies operands just after a rising edge and pushes the expected `{co, sum}` into a queue. The monitor pops that entry at the following falling edge and compares it there. Each queued entry is therefore checked half a period after its inputs changed, and never against a later vector.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int unsigned SZ_BITS  = 8;
    localparam int unsigned MAX_BLKS = 16;
    localparam int unsigned SZ_VEC   = SZ_BITS * MAX_BLKS;

    // Width of block k, read from a packed list (block 0 in the low byte).
    function automatic int unsigned blk_size(input logic [SZ_VEC-1:0] sizes,
                                             input int unsigned k);
        return int'(sizes[k*SZ_BITS +: SZ_BITS]);
    endfunction

    // Lowest bit position covered by block k.
    function automatic int unsigned blk_base(input logic [SZ_VEC-1:0] sizes,
                                             input int unsigned k);
        int unsigned acc;
        acc = 0;
        for (int unsigned j = 0; j < k; j++) begin
            acc = acc + blk_size(sizes, j);
        end
        return acc;
    endfunction

endpackage

// File: rtl/csel_setup.sv
module csel_setup #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prop,
    output logic [W-1:0] gen
);

    always_comb begin
        prop = a ^ b;
        gen  = a & b;
    end

endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] chain;

    always_comb begin
        chain[0] = cin;
        for (int unsigned i = 0; i < W; i++) begin
            chain[i+1] = gen[i] | (prop[i] & chain[i]);
        end
        sum  = prop ^ chain[W-1:0];
        cout = chain[W];
    end

    // R5: a chain whose every bit propagates passes its carry-in straight out
    always_comb begin
        if (&prop) begin
            a_r5_prop_passes: assert (cout == cin);
        end
    end

    // R1: a chain with neither propagate nor generate anywhere leaves no carry
    always_comb begin
        if (~|(prop | gen)) begin
            a_r1_kill_zero: assert (cout == 1'b0);
        end
    end

endmodule

// File: rtl/csel_block.sv
module csel_block #(
    parameter int unsigned W    = 4,
    parameter bit          DUAL = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] prop;
    logic [W-1:0] gen;

    csel_setup #(.W(W)) u_setup (
        .a    (a),
        .b    (b),
        .prop (prop),
        .gen  (gen)
    );

    generate
        if (DUAL) begin : g_dual
            logic [W-1:0] sum_h0;
            logic [W-1:0] sum_h1;
            logic         co_h0;
            logic         co_h1;

            csel_ripple #(.W(W)) u_hyp0 (
                .prop (prop),
                .gen  (gen),
                .cin  (1'b0),
                .sum  (sum_h0),
                .cout (co_h0)
            );

            csel_ripple #(.W(W)) u_hyp1 (
                .prop (prop),
                .gen  (gen),
                .cin  (1'b1),
                .sum  (sum_h1),
                .cout (co_h1)
            );

            always_comb begin
                sum  = cin ? sum_h1 : sum_h0;
                cout = cin ? co_h1  : co_h0;
            end

            // R4: assuming a carry-in of 1 can never lose a carry-out
            always_comb begin
                a_r4_hyp_order: assert (!(co_h0 && !co_h1));
            end
        end else begin : g_single
            csel_ripple #(.W(W)) u_chain (
                .prop (prop),
                .gen  (gen),
                .cin  (cin),
                .sum  (sum),
                .cout (cout)
            );
        end
    endgenerate

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
    parameter int unsigned           WIDTH = 20,
    parameter int unsigned           NBLK  = 5,
    parameter logic [NBLK*8-1:0]     BLK_W = {8'd6, 8'd5, 8'd4, 8'd3, 8'd2}
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             ci,
    output logic [WIDTH-1:0] sum,
    output logic             co
);

    import csel_pkg::*;

    localparam logic [SZ_VEC-1:0] SIZES = SZ_VEC'(BLK_W);
    localparam int unsigned       TOTAL = blk_base(SIZES, NBLK);

    generate
        if (TOTAL != WIDTH || NBLK > MAX_BLKS) begin : g_bad_partition
            $error("sqrt_csel_adder: block widths do not sum to WIDTH");
        end
    endgenerate

    logic [NBLK:0] sel_c;

    assign sel_c[0] = ci;
    assign co       = sel_c[NBLK];

    generate
        for (genvar k = 0; k < NBLK; k++) begin : g_blk
            localparam int unsigned BW = blk_size(SIZES, k);
            localparam int unsigned LO = blk_base(SIZES, k);

            csel_block #(.W(BW), .DUAL(k != 0)) u_blk (
                .a    (a[LO +: BW]),
                .b    (b[LO +: BW]),
                .cin  (sel_c[k]),
                .sum  (sum[LO +: BW]),
                .cout (sel_c[k+1])
            );
        end
    endgenerate

    // R1: the block chain agrees with a behavioural add
    always_comb begin
        a_r1_sum_exact: assert ({co, sum} ==
            ((WIDTH+1)'(a) + (WIDTH+1)'(b) + (WIDTH+1)'(ci)));
    end

endmodule

// File: tb/sim_sqrt_csel_adder.sv
module sim_sqrt_csel_adder;

    localparam int unsigned CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    // default 20-bit, blocks 2,3,4,5,6
    logic [19:0] a0, b0, s0;
    logic        c0, o0;
    // uniform 16-bit, four 4-bit blocks
    logic [15:0] a1, b1, s1;
    logic        c1, o1;
    // 6-bit, blocks 1,2,3
    logic [5:0]  a2, b2, s2;
    logic        c2, o2;

    sqrt_csel_adder u0 (.a(a0), .b(b0), .ci(c0), .sum(s0), .co(o0));

    sqrt_csel_adder #(.WIDTH(16), .NBLK(4),
                      .BLK_W({8'd4, 8'd4, 8'd4, 8'd4})) u_uni (
        .a(a1), .b(b1), .ci(c1), .sum(s1), .co(o1));

    sqrt_csel_adder #(.WIDTH(6), .NBLK(3),
                      .BLK_W({8'd3, 8'd2, 8'd1})) u_small (
        .a(a2), .b(b2), .ci(c2), .sum(s2), .co(o2));

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    int unsigned q_dut[$];
    logic [20:0] q_exp[$];
    string       q_tag[$];

    task automatic drive20(input logic [19:0] a, input logic [19:0] b,
                           input logic ci, input logic [20:0] exp, input string tag);
        @(posedge clk);
        a0 = a; b0 = b; c0 = ci;
        q_dut.push_back(0); q_exp.push_back(exp); q_tag.push_back(tag);
    endtask

    task automatic drive16(input logic [15:0] a, input logic [15:0] b,
                           input logic ci, input string tag);
        @(posedge clk);
        a1 = a; b1 = b; c1 = ci;
        q_dut.push_back(1);
        q_exp.push_back(21'(a) + 21'(b) + 21'(ci));
        q_tag.push_back(tag);
    endtask

    task automatic drive6(input logic [5:0] a, input logic [5:0] b,
                          input logic ci, input string tag);
        @(posedge clk);
        a2 = a; b2 = b; c2 = ci;
        q_dut.push_back(2);
        q_exp.push_back(21'(a) + 21'(b) + 21'(ci));
        q_tag.push_back(tag);
    endtask

    function automatic logic [20:0] ref20(input logic [19:0] a, input logic [19:0] b,
                                          input logic ci);
        return 21'(a) + 21'(b) + 21'(ci);
    endfunction

    // Monitor: results are due in the same cycle, sampled at the falling edge.
    always @(negedge clk) begin
        if (!rst && q_dut.size() != 0) begin
            int unsigned d;
            logic [20:0] e, act;
            string       t;
            d = q_dut.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
            case (d)
                0:       act = {o0, s0};
                1:       act = 21'({o1, s1});
                default: act = 21'({o2, s2});
            endcase
            n_checks++;
            if (act !== e) begin
                n_fail++;
                $display("FAIL %s dut=%0d actual=%h expected=%h", t, d, act, e);
            end
        end
    end

    initial begin
        a0 = '0; b0 = '0; c0 = 1'b0;
        a1 = '0; b1 = '0; c1 = 1'b0;
        a2 = '0; b2 = '0; c2 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // zero inputs after reset give a zero result (R1)
        drive20(20'h0, 20'h0, 1'b0, 21'h0, "R1 idle");
        // R3: carry-in alone, and a carry leaving bits 0-1
        drive20(20'h0, 20'h0, 1'b1, 21'h1, "R3 cin only");
        drive20(20'h3, 20'h0, 1'b1, 21'h4, "R3 exit block0");
        // R2: carry crossing each block boundary (bits 2, 5, 9, 14)
        drive20(20'h00002, 20'h00002, 1'b0, 21'h00004, "R2 boundary 2");
        drive20(20'h00010, 20'h00010, 1'b0, 21'h00020, "R2 boundary 5");
        drive20(20'h00100, 20'h00100, 1'b0, 21'h00200, "R2 boundary 9");
        drive20(20'h02000, 20'h02000, 1'b0, 21'h04000, "R2 boundary 14");
        // R4: selected carry picks the 1-hypothesis and feeds the next block
        drive20(20'h0001F, 20'h00001, 1'b0, 21'h00020, "R4 select one");
        drive20(20'h001FC, 20'h00000, 1'b1, 21'h001FD, "R4 select zero");
        drive20(20'h001FF, 20'h00000, 1'b1, 21'h00200, "R4 chained select");
        // R5: full propagate
        drive20(20'hAAAAA, 20'h55555, 1'b0, 21'h0FFFFF, "R5 prop ci0");
        drive20(20'hAAAAA, 20'h55555, 1'b1, 21'h100000, "R5 prop ci1");
        // R6: generate at bit 0 through all blocks
        drive20(20'h00001, 20'hFFFFF, 1'b0, 21'h100000, "R6 ripple all");
        // R7: carry-out from last block
        drive20(20'h80000, 20'h80000, 1'b0, 21'h100000, "R7 msb gen");
        drive20(20'hC0000, 20'h40000, 1'b1, 21'h100001, "R7 msb carry-in");
        drive20(20'hFFFFF, 20'hFFFFF, 1'b1, 21'h1FFFFF, "R7 max");
        // R1: random 20-bit vectors, both carry-in values
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] ra, rb;
            logic        rc;
            ra = 20'($urandom); rb = 20'($urandom); rc = 1'(i);
            drive20(ra, rb, rc, ref20(ra, rb, rc), "R1 random");
        end
        // R8: uniform 4-bit blocks over 16 bits
        drive16(16'hFFFF, 16'h0001, 1'b0, "R8 ripple all");
        drive16(16'h0F0F, 16'hF0F0, 1'b1, "R8 prop ci1");
        for (int i = 0; i < 2000; i++) begin
            drive16(16'($urandom), 16'($urandom), 1'($urandom), "R8 random");
        end
        // R9: exhaustive 6-bit with 1-bit block
        for (int i = 0; i < 8192; i++) begin
            drive6(6'(i), 6'(i >> 6), 1'(i >> 12), "R9 exhaustive");
        end

        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule